// File: doc/BRIEF.md
# Dual-Word Trace Capture Buffer

This block collects 128-bit trace records from a producer and holds them in first-in, first-out order until a host drains them. A record is accepted on any cycle where the capture strobe is high and the buffer has room. With default parameters the storage holds 1024 records. When the buffer is full, further captures are lost, and a sticky overflow flag records that loss.

The host has a 64-bit data path, so it reads each record in two steps. A low-word read returns the lower half of the oldest record and changes nothing else. A high-word read returns the upper half and retires the record. The read result appears on the data output one cycle after the read strobe and stays there until the next read.

A 32-bit status word reports the fill level, the full and empty flags and the overflow flag. Any write strobe on the status word clears the overflow flag. The block pairs the two halves of a read: if the low word was read while the buffer was empty, the matching high-word read also returns zero, even when a record has arrived in between.

Top module: `trace_capture_buf`

## Requirements
- R1: When `cap_valid_i` is high and the buffer is not full, `cap_rec_i` is appended behind all stored records, and the count in the status word rises by one.
- R2: A low-word read of a non-empty buffer returns bits 63:0 of the oldest record on `rd_data_o` in the next cycle. It changes neither the count nor the flags, and it may be repeated.
- R3: A high-word read of a non-empty buffer returns bits 127:64 of the oldest record on `rd_data_o` in the next cycle and removes that record. Records leave in the order they arrived.
- R4: A low-word or high-word read while the buffer is empty returns zero and leaves the count unchanged.
- R5: `status_o` bit 12 is overflow, bit 11 is full, bit 10 is empty, and bits 9:0 are the record count; all other bits are 0. After reset the word reads 0x400 and `rd_data_o` reads 0.
- R6: With 1024 records stored, the full flag is 1, the empty flag is 0 and the count field reads 0.
- R7: A capture attempted while full is discarded without disturbing stored records, and the overflow flag is set. This holds even when a high-word read pops a record in the same cycle.
- R8: The overflow flag stays set until `stat_wr_i` is pulsed. If a discarded capture occurs in the same cycle as the status write, the flag remains set.
- R9: A capture and a popping high-word read in the same cycle leave the count unchanged and advance both the write and read positions.
- R10: A high-word read that follows a low-word read returns the upper half of the same record as that low-word read. If the low-word read found the buffer empty, the high-word read returns zero and pops nothing, even if a record was captured in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid_i | input | 1 | Capture strobe from the producer |
| cap_rec_i | input | 128 | Trace record to capture |
| rd_lo_i | input | 1 | Host low-word read strobe |
| rd_hi_i | input | 1 | Host high-word read strobe (pops the record) |
| rd_data_o | output | 64 | Read result, valid the cycle after a read strobe |
| stat_wr_i | input | 1 | Status write strobe; clears the overflow flag |
| status_o | output | 32 | Overflow, full, empty and record count |

## Verification
The assertions assume that the host never raises the low-word and high-word read strobes in the same cycle. The design resolves that case in favour of the low word, but the properties that pair reads with results are written only for a single read kind per cycle. The assertions also assume that pops come only from the read sequencer. The stimulus issues each read in a cycle of its own and mixes captures and status writes into those cycles, so the overlap rules for capture with pop and for drop with clear are still exercised.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2
    } rd_op_e;

    // The low-word strobe wins if both strobes arrive together.
    function automatic rd_op_e decode_rd(input logic lo, input logic hi);
        if (lo) begin
            return RD_LOW;
        end
        if (hi) begin
            return RD_HIGH;
        end
        return RD_IDLE;
    endfunction

endpackage

// File: rtl/trc_store.sv
module trc_store #(
    parameter int REC_W = 128,
    parameter int DEPTH = 1024,
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [REC_W-1:0] wr_rec,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [REC_W-1:0] rd_rec
);
    localparam int NUM_BANKS = 2;
    localparam int HALF_W    = REC_W / NUM_BANKS;

    // One bank per host word; both banks share the same addresses.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [HALF_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en) begin
                bank[wr_ptr] <= wr_rec[g*HALF_W +: HALF_W];
            end
        end

        assign rd_rec[g*HALF_W +: HALF_W] = bank[rd_ptr];
    end

endmodule

// File: rtl/trc_ptrs.sv
module trc_ptrs #(
    parameter int DEPTH = 1024,
    parameter int PTR_W = 10,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_req,
    input  logic             pop_req,
    input  logic             ovf_clr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] cnt_field,
    output logic             full,
    output logic             empty,
    output logic             ovf
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    always_comb begin
        st_d    = st_q;
        push_ok = cap_req & ~full;
        pop_ok  = pop_req & ~empty;

        if (push_ok) begin
            st_d.wr = step_ptr(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = step_ptr(st_q.rd);
        end

        unique case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase

        // A drop in the same cycle as a clear leaves the flag set.
        if (ovf_clr) begin
            st_d.ovf = 1'b0;
        end
        if (cap_req && full) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr    = st_q.wr;
    assign rd_ptr    = st_q.rd;
    assign cnt_field = st_q.cnt[PTR_W-1:0];
    assign ovf       = st_q.ovf;

endmodule

// File: rtl/trc_rdseq.sv
module trc_rdseq
    import trc_pkg::*;
#(
    parameter int REC_W = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_lo,
    input  logic                 rd_hi,
    input  logic                 empty,
    input  logic [REC_W-1:0]     head_rec,
    output logic                 pop,
    output logic [REC_W/2-1:0]   rd_data
);
    localparam int HALF_W = REC_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] data;
        logic              pair_open;
        logic              pair_live;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        pop  = 1'b0;
        unique case (decode_rd(rd_lo, rd_hi))
            RD_LOW: begin
                sq_d.data      = empty ? '0 : head_rec[HALF_W-1:0];
                sq_d.pair_open = 1'b1;
                sq_d.pair_live = ~empty;
            end
            RD_HIGH: begin
                if (sq_q.pair_open && !sq_q.pair_live) begin
                    // The low half came from an empty buffer: keep the pair consistent.
                    sq_d.data = '0;
                end else if (empty) begin
                    sq_d.data = '0;
                end else begin
                    sq_d.data = head_rec[REC_W-1:HALF_W];
                    pop       = 1'b1;
                end
                sq_d.pair_open = 1'b0;
                sq_d.pair_live = 1'b0;
            end
            default: begin
                sq_d = sq_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign rd_data = sq_q.data;

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int REC_W  = 128,
    parameter int DEPTH  = 1024,
    parameter int STAT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_valid_i,
    input  logic [REC_W-1:0]    cap_rec_i,
    input  logic                rd_lo_i,
    input  logic                rd_hi_i,
    output logic [REC_W/2-1:0]  rd_data_o,
    input  logic                stat_wr_i,
    output logic [STAT_W-1:0]   status_o
);
    localparam int HALF_W    = REC_W / 2;
    localparam int PTR_W     = $clog2(DEPTH);
    localparam int CNT_W     = PTR_W + 1;
    localparam int POS_EMPTY = PTR_W;
    localparam int POS_FULL  = PTR_W + 1;
    localparam int POS_OVF   = PTR_W + 2;

    logic             push_ok;
    logic             pop_ok;
    logic             pop_req;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] cnt_field;
    logic             full;
    logic             empty;
    logic             ovf;
    logic [REC_W-1:0] head_rec;

    trc_ptrs #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_req   (cap_valid_i),
        .pop_req   (pop_req),
        .ovf_clr   (stat_wr_i),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .cnt_field (cnt_field),
        .full      (full),
        .empty     (empty),
        .ovf       (ovf)
    );

    trc_store #(
        .REC_W (REC_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (push_ok),
        .wr_ptr (wr_ptr),
        .wr_rec (cap_rec_i),
        .rd_ptr (rd_ptr),
        .rd_rec (head_rec)
    );

    trc_rdseq #(
        .REC_W (REC_W)
    ) u_rdseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lo    (rd_lo_i),
        .rd_hi    (rd_hi_i),
        .empty    (empty),
        .head_rec (head_rec),
        .pop      (pop_req),
        .rd_data  (rd_data_o)
    );

    always_comb begin
        status_o                 = '0;
        status_o[PTR_W-1:0]      = cnt_field;
        status_o[POS_EMPTY]      = empty;
        status_o[POS_FULL]       = full;
        status_o[POS_OVF]        = ovf;
    end

endmodule

// File: rtl/trc_buf_chk.sv
module trc_buf_chk #(
    parameter int PTR_W  = 10,
    parameter int HALF_W = 64,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid_i,
    input logic              rd_lo_i,
    input logic              rd_hi_i,
    input logic              stat_wr_i,
    input logic              push_ok,
    input logic              pop_ok,
    input logic [HALF_W-1:0] rd_data_o,
    input logic [STAT_W-1:0] status_o
);
    localparam int B_EMPTY = PTR_W;
    localparam int B_FULL  = PTR_W + 1;
    localparam int B_OVF   = PTR_W + 2;

    logic full_s, empty_s, ovf_s;
    assign full_s  = status_o[B_FULL];
    assign empty_s = status_o[B_EMPTY];
    assign ovf_s   = status_o[B_OVF];

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_s && empty_s));

    p_full_cnt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_s |-> status_o[PTR_W-1:0] == '0);

    p_push_leaves_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && !pop_ok |=> !empty_s);

    p_lo_keeps_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i && !cap_valid_i |=> status_o[B_FULL:0] == $past(status_o[B_FULL:0]));

    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> !empty_s && rd_hi_i && !rd_lo_i);

    p_empty_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i && !rd_lo_i && empty_s |=> rd_data_o == '0);

    p_drop_sets_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_i && full_s |=> ovf_s);

    p_no_push_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_s |-> !push_ok);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_s && !stat_wr_i |=> ovf_s);

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i && !(cap_valid_i && full_s) |=> !ovf_s);

    p_cap_pop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && pop_ok |=> status_o[B_FULL:0] == $past(status_o[B_FULL:0]));

endmodule

bind trace_capture_buf trc_buf_chk #(
    .PTR_W  (PTR_W),
    .HALF_W (HALF_W),
    .STAT_W (STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid_i (cap_valid_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .stat_wr_i   (stat_wr_i),
    .push_ok     (push_ok),
    .pop_ok      (pop_ok),
    .rd_data_o   (rd_data_o),
    .status_o    (status_o)
);

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_valid_i = 1'b0;
    logic [127:0] cap_rec_i = '0;
    logic         rd_lo_i = 1'b0;
    logic         rd_hi_i = 1'b0;
    logic         stat_wr_i = 1'b0;
    logic [63:0]  rd_data_o;
    logic [31:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [127:0] ref_q[$];
    logic [63:0]  exp_q[$];
    string        tag_q[$];
    bit           m_open = 1'b0;
    bit           m_live = 1'b0;
    bit           m_ovf  = 1'b0;
    bit           pend   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_capture_buf u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid_i),
        .cap_rec_i   (cap_rec_i),
        .rd_lo_i     (rd_lo_i),
        .rd_hi_i     (rd_hi_i),
        .rd_data_o   (rd_data_o),
        .stat_wr_i   (stat_wr_i),
        .status_o    (status_o)
    );

    function automatic logic [127:0] mk(input int i);
        return {32'(i) * 32'h9E37_79B9, ~32'(i), 32'(i) ^ 32'h5A5A_5A5A, 32'(i) + 32'h0001_0000};
    endfunction

    // Monitor: a strobe seen at one falling edge has its result at the next.
    always @(negedge clk) begin
        if (pend) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data_o !== e) begin
                errors++;
                $display("FAIL %s rd_data actual %h expected %h", t, rd_data_o, e);
            end
        end
        pend = rd_lo_i | rd_hi_i;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: predicts the outcome of one cycle from the requirements, then drives it.
    task automatic cycle(input bit cap, input logic [127:0] rec, input bit lo,
                         input bit hi, input bit sw, input string tag);
        bit was_full;
        bit was_empty;
        bit do_pop;
        logic [63:0] e;
        was_full  = (ref_q.size() == DEPTH);
        was_empty = (ref_q.size() == 0);
        do_pop    = 1'b0;
        e         = '0;
        if (lo) begin
            e      = was_empty ? 64'd0 : ref_q[0][63:0];
            m_open = 1'b1;
            m_live = !was_empty;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end else if (hi) begin
            if (m_open && !m_live) begin
                e = '0;
            end else if (was_empty) begin
                e = '0;
            end else begin
                e      = ref_q[0][127:64];
                do_pop = 1'b1;
            end
            m_open = 1'b0;
            m_live = 1'b0;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (sw) m_ovf = 1'b0;
        if (cap && was_full) m_ovf = 1'b1;
        if (do_pop) void'(ref_q.pop_front());
        if (cap && !was_full) ref_q.push_back(rec);

        cap_valid_i = cap;
        cap_rec_i   = rec;
        rd_lo_i     = lo;
        rd_hi_i     = hi;
        stat_wr_i   = sw;
        tick();
        cap_valid_i = 1'b0;
        rd_lo_i     = 1'b0;
        rd_hi_i     = 1'b0;
        stat_wr_i   = 1'b0;
    endtask

    task automatic chk_status(input string tag);
        logic [31:0] e;
        e        = '0;
        e[9:0]   = 10'(ref_q.size());
        e[10]    = (ref_q.size() == 0);
        e[11]    = (ref_q.size() == DEPTH);
        e[12]    = m_ovf;
        checks++;
        if (status_o !== e) begin
            errors++;
            $display("FAIL %s status actual %h expected %h", tag, status_o, e);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();

        // R5: reset state of the status word and read data
        chk_status("R5 reset");
        checks++;
        if (rd_data_o !== 64'd0) begin
            errors++;
            $display("FAIL R5 reset rd_data actual %h expected 0", rd_data_o);
        end

        // R1: captures raise the count
        for (int i = 0; i < 3; i++) cycle(1, mk(i), 0, 0, 0, "R1");
        chk_status("R1 three stored");

        // R2: low reads return the low half without changing state
        cycle(0, '0, 1, 0, 0, "R2 low read");
        chk_status("R2 count kept");
        cycle(0, '0, 1, 0, 0, "R2 repeat low read");

        // R3: high reads pop in arrival order
        cycle(0, '0, 0, 1, 0, "R3 high read pops");
        chk_status("R3 count after pop");
        cycle(0, '0, 0, 1, 0, "R3 high read alone");

        // R9: capture and pop together
        cycle(1, mk(3), 0, 1, 0, "R9 pop with capture");
        chk_status("R9 count unchanged");
        cycle(0, '0, 1, 0, 0, "R3 low of new record");
        cycle(0, '0, 0, 1, 0, "R3 high of new record");

        // R4: reads of an empty buffer
        cycle(0, '0, 0, 1, 0, "R4 high read empty");
        cycle(0, '0, 1, 0, 0, "R4 low read empty");
        cycle(0, '0, 0, 1, 0, "R4 high after empty low");
        chk_status("R4 still empty");

        // R10: pairing across an arrival
        cycle(0, '0, 1, 0, 0, "R10 low read empty");
        cycle(1, mk(4), 0, 0, 0, "R10 arrival");
        cycle(0, '0, 0, 1, 0, "R10 high stays zero");
        chk_status("R10 no pop");
        cycle(1, mk(5), 1, 0, 0, "R10 low with capture");
        cycle(1, mk(6), 0, 0, 0, "R10 capture between");
        cycle(0, '0, 0, 1, 0, "R10 high same record");
        for (int i = 0; i < 2; i++) begin
            cycle(0, '0, 1, 0, 0, "R10 drain low");
            cycle(0, '0, 0, 1, 0, "R10 drain high");
        end
        chk_status("R10 drained");

        // R6: fill to capacity
        for (int i = 0; i < DEPTH; i++) cycle(1, mk(100 + i), 0, 0, 0, "R1 fill");
        chk_status("R6 full");

        // R7: drop while full
        cycle(1, mk(9999), 0, 0, 0, "R7 drop");
        chk_status("R7 overflow set");
        cycle(0, '0, 1, 0, 0, "R7 oldest intact");
        cycle(0, '0, 0, 1, 0, "R7 oldest high");
        chk_status("R8 sticky after pop");
        cycle(0, '0, 0, 0, 1, "R8 clear");
        chk_status("R8 cleared");
        cycle(1, mk(7), 0, 0, 0, "R1 refill");
        cycle(1, mk(8), 0, 1, 0, "R7 drop with pop");
        chk_status("R7 drop with pop");
        cycle(1, mk(9), 0, 0, 0, "R1 refill again");
        cycle(1, mk(10), 0, 0, 1, "R8 drop with clear");
        chk_status("R8 set wins");
        cycle(0, '0, 0, 0, 1, "R8 clear again");
        chk_status("R8 cleared again");

        // R3: drain everything in order
        while (ref_q.size() > 0) begin
            cycle(0, '0, 1, 0, 0, "R3 drain low");
            cycle(0, '0, 0, 1, 0, "R3 drain high");
        end
        tick();
        tick();
        chk_status("R5 final empty");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule